// File: doc/BRIEF.md
# Mode-Selectable Synchronous FIFO

This block is a single-clock first-in first-out buffer whose read timing is fixed for the whole run by a mode level sampled shortly after reset. In standard mode the two status outputs behave as not-empty and not-full indications, and a word reaches the read data output only when the consumer issues a read. In fall-through mode the same outputs mean output-ready and input-ready: the first word written into an empty buffer is presented on the read data output at once, and each read then advances to the next stored word.

Reset is asynchronous and active low. After release, a two-edge start-up sequence samples the mode and opens the write side. Two threshold outputs, both active low, report a nearly empty or nearly full buffer against offsets that the surrounding logic drives as plain inputs. Capacity is `2**AW` words in both modes. In fall-through mode the word held at the output counts toward the fill level.

Top module: `fmc_core`

## Requirements
- R1: Driving `rst_n` low clears the stored words, the pointers and all flags at once, without waiting for a clock edge.
- R2: While `rst_n` is low, `in_rdy` is 0, `out_rdy` is 0, `near_empty_n` is 0 and `near_full_n` is 1.
- R3: `in_rdy` first rises on the second rising clock edge after `rst_n` goes high. A write presented on either of those two edges is dropped.
- R4: `mode_sel` is sampled on the second rising edge after reset release. A value of 1 selects standard mode and 0 selects fall-through mode.
- R5: After it has been sampled, `mode_sel` has no effect until the next reset.
- R6: In standard mode `rd_data` changes only on an accepted read, which loads the oldest stored word. `out_rdy` is 1 exactly while at least one word is stored.
- R7: In fall-through mode, a write accepted while `out_rdy` is 0 puts that word on `rd_data` and raises `out_rdy` on the same edge. Every later word is presented only after an accepted read of the word before it. A read of the last word drops `out_rdy`.
- R8: A write is accepted only while `in_rdy` is 1. `in_rdy` is 0 once `2**AW` words are held, and a write attempted then changes nothing.
- R9: A read is accepted only while `out_rdy` is 1. A read attempted while `out_rdy` is 0 leaves `rd_data` and the fill level unchanged.
- R10: `near_empty_n` is 0 while the fill level is at or below `ae_ofs`, and 1 above it.
- R11: `near_full_n` is 1 while the free space (`2**AW` minus the fill level) is greater than `af_ofs`, and 0 otherwise.
- R12: Words leave in the order they were written, in both modes, and the fill level never exceeds `2**AW`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Timing mode level: 1 standard, 0 fall-through |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Read data register |
| ae_ofs | input | AW+1 | Near-empty threshold, in words |
| af_ofs | input | AW+1 | Near-full threshold, in free words |
| in_rdy | output | 1 | Full flag (standard) or input-ready (fall-through), high when a write is possible |
| out_rdy | output | 1 | Empty flag (standard) or output-ready (fall-through), high when a read is possible |
| near_empty_n | output | 1 | Low while the fill level is at or below `ae_ofs` |
| near_full_n | output | 1 | Low while the free space is at or below `af_ofs` |

## Verification
A wrong fill count shows on the next edge as a wrong `out_rdy`, `in_rdy` or threshold flag once the level crosses a boundary. The bench drives the level to zero, to each threshold and to full so that such an error cannot stay hidden. A slipped read or write pointer appears as a wrong word on `rd_data` at the first read after the slip, which the ordered drain sequences catch. A wrongly latched mode appears on the very first write into an empty buffer, as a word that falls through or fails to. A late or early start-up appears as an `in_rdy` level checked at each of the two edges after reset release.

// File: rtl/fmc_pkg.sv
package fmc_pkg;

    typedef enum logic {
        MODE_FALL = 1'b0,
        MODE_STD  = 1'b1
    } fifo_mode_e;

endpackage

// File: rtl/fmc_startup.sv
module fmc_startup
    import fmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_sel,
    output logic       ready,
    output fifo_mode_e mode
);

    typedef struct packed {
        logic [1:0] step;
        fifo_mode_e mode;
    } start_s;

    start_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.step != 2'd2) begin
            st_d.step = st_q.step + 2'd1;
            if (st_q.step == 2'd1) begin
                st_d.mode = fifo_mode_e'(mode_sel);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{step: 2'd0, mode: MODE_STD};
        end else begin
            st_q <= st_d;
        end
    end

    assign ready = (st_q.step == 2'd2);
    assign mode  = st_q.mode;

    // R5: once sampled, the mode holds until reset
    assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready)) |-> $stable(mode))
        else $error("mode changed after sampling");

endmodule

// File: rtl/fmc_ram.sv
module fmc_ram #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/fmc_level_flags.sv
module fmc_level_flags #(
    parameter int AW = 4
) (
    input  logic        ready,
    input  logic [AW:0] level,
    input  logic [AW:0] ae_ofs,
    input  logic [AW:0] af_ofs,
    output logic        near_empty_n,
    output logic        near_full_n
);

    localparam int          LW      = AW + 1;
    localparam logic [AW:0] DEPTH_L = LW'(1 << AW);

    logic [AW:0] free_words;

    always_comb begin
        free_words   = DEPTH_L - level;
        near_empty_n = ready && (level > ae_ofs);
        near_full_n  = !ready || (free_words > af_ofs);
    end

endmodule

// File: rtl/fmc_core.sv
module fmc_core
    import fmc_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic [AW:0]   ae_ofs,
    input  logic [AW:0]   af_ofs,
    output logic          in_rdy,
    output logic          out_rdy,
    output logic          near_empty_n,
    output logic          near_full_n
);

    localparam int          LW      = AW + 1;
    localparam logic [AW:0] DEPTH_L = LW'(1 << AW);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [AW:0]   cnt;
        logic          ov;
        logic [DW-1:0] dout;
    } core_s;

    core_s      c_d, c_q;
    logic       ready;
    fifo_mode_e mode;
    logic       wr_ok, rd_ok, ram_we, pop, bypass;
    logic [AW:0]   level;
    logic [DW-1:0] ram_rdata;

    fmc_startup i_startup (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .ready    (ready),
        .mode     (mode)
    );

    fmc_ram #(.DW(DW), .AW(AW)) i_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (c_q.wptr),
        .wdata (wr_data),
        .raddr (c_q.rptr),
        .rdata (ram_rdata)
    );

    fmc_level_flags #(.AW(AW)) i_flags (
        .ready        (ready),
        .level        (level),
        .ae_ofs       (ae_ofs),
        .af_ofs       (af_ofs),
        .near_empty_n (near_empty_n),
        .near_full_n  (near_full_n)
    );

    assign level   = c_q.cnt + LW'(c_q.ov);
    assign in_rdy  = ready && (level != DEPTH_L);
    assign out_rdy = (mode == MODE_STD) ? (c_q.cnt != '0) : c_q.ov;
    assign wr_ok   = wr_en && in_rdy;
    assign rd_ok   = rd_en && out_rdy;
    assign rd_data = c_q.dout;

    always_comb begin
        c_d    = c_q;
        ram_we = 1'b0;
        pop    = 1'b0;
        bypass = 1'b0;
        if (mode == MODE_STD) begin
            ram_we = wr_ok;
            if (rd_ok) begin
                c_d.dout = ram_rdata;
                pop      = 1'b1;
            end
        end else begin
            bypass = wr_ok && (c_q.cnt == '0) && (!c_q.ov || rd_ok);
            ram_we = wr_ok && !bypass;
            if (rd_ok || !c_q.ov) begin
                if (c_q.cnt != '0) begin
                    c_d.dout = ram_rdata;
                    c_d.ov   = 1'b1;
                    pop      = 1'b1;
                end else if (bypass) begin
                    c_d.dout = wr_data;
                    c_d.ov   = 1'b1;
                end else begin
                    c_d.ov   = 1'b0;
                end
            end
        end
        if (ram_we) c_d.wptr = c_q.wptr + 1'b1;
        if (pop)    c_d.rptr = c_q.rptr + 1'b1;
        c_d.cnt = c_q.cnt + LW'(ram_we) - LW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    // Independent edge counter since reset release, for the start-up check
    logic [1:0] since_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_q <= 2'd0;
        else if (since_q != 2'd2)  since_q <= since_q + 2'd1;
    end

    assert_start_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready == (since_q == 2'd2))
        else $error("start-up length wrong");

    assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        level <= DEPTH_L)
        else $error("fill level above capacity");

    assert_write_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_rdy) |=> (level <= $past(level)))
        else $error("blocked write raised the level");

    assert_read_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_rdy && !wr_en) |=> ($stable(rd_data) && level == $past(level)))
        else $error("blocked read changed state");

    assert_std_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STD && !(rd_en && out_rdy)) |=> $stable(rd_data))
        else $error("standard mode output moved without read");

    assert_fall_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FALL && !out_rdy && wr_en && in_rdy)
            |=> (out_rdy && rd_data == $past(wr_data)))
        else $error("first word did not fall through");

endmodule

// File: tb/test_fmc_core.sv
module test_fmc_core;
    import fmc_pkg::*;

    localparam int DW = 8;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_sel = 1'b1;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic [AW:0]   ae_ofs = 5'd2;
    logic [AW:0]   af_ofs = 5'd13;
    logic          in_rdy, out_rdy, near_empty_n, near_full_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fmc_core #(.DW(DW), .AW(AW)) i_fmc_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_sel     (mode_sel),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_en        (rd_en),
        .rd_data      (rd_data),
        .ae_ofs       (ae_ofs),
        .af_ofs       (af_ofs),
        .in_rdy       (in_rdy),
        .out_rdy      (out_rdy),
        .near_empty_n (near_empty_n),
        .near_full_n  (near_full_n)
    );

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [7:0] din;
        logic [7:0] dout;
        logic       ordy;
        logic       ae_n;
        logic       af_n;
    } vec_t;

    // Standard mode, ae_ofs = 2, af_ofs = 13
    localparam vec_t VEC [11] = '{
        '{1'b1, 1'b0, 8'hA1, 8'h00, 1'b1, 1'b0, 1'b1},
        '{1'b1, 1'b0, 8'hA2, 8'h00, 1'b1, 1'b0, 1'b1},
        '{1'b1, 1'b0, 8'hA3, 8'h00, 1'b1, 1'b1, 1'b0},
        '{1'b0, 1'b1, 8'h00, 8'hA1, 1'b1, 1'b0, 1'b1},
        '{1'b1, 1'b1, 8'hA4, 8'hA2, 1'b1, 1'b0, 1'b1},
        '{1'b0, 1'b0, 8'h00, 8'hA2, 1'b1, 1'b0, 1'b1},
        '{1'b0, 1'b1, 8'h00, 8'hA3, 1'b1, 1'b0, 1'b1},
        '{1'b0, 1'b1, 8'h00, 8'hA4, 1'b0, 1'b0, 1'b1},
        '{1'b0, 1'b1, 8'h00, 8'hA4, 1'b0, 1'b0, 1'b1},
        '{1'b1, 1'b0, 8'hA5, 8'hA4, 1'b1, 1'b0, 1'b1},
        '{1'b0, 1'b1, 8'h00, 8'hA5, 1'b0, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic [7:0] d, input logic r);
        wr_en = w; wr_data = d; rd_en = r;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic do_reset(input logic m, input logic wr_during);
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; mode_sel = m;
        repeat (4) @(negedge clk);
        chk("R2 in_rdy", in_rdy, 0);
        chk("R2 out_rdy", out_rdy, 0);
        chk("R2 near_empty_n", near_empty_n, 0);
        chk("R2 near_full_n", near_full_n, 1);
        rst_n = 1'b1;
        wr_en = wr_during; wr_data = 8'h5A;
        @(posedge clk); @(negedge clk);
        chk("R3 in_rdy after edge 1", in_rdy, 0);
        @(posedge clk); @(negedge clk);
        chk("R3 in_rdy after edge 2", in_rdy, 1);
        wr_en = 1'b0;
        chk("R3 startup write dropped", out_rdy, 0);
        mode_sel = ~m;  // R5: late change must not matter
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // Standard mode run, mode_sel flipped after sampling (R5)
        do_reset(1'b1, 1'b1);
        foreach (VEC[i]) begin
            step(VEC[i].wr, VEC[i].din, VEC[i].rd);
            chk($sformatf("R6/R9 vec %0d rd_data", i), rd_data, VEC[i].dout);
            chk($sformatf("R6 vec %0d out_rdy", i), out_rdy, VEC[i].ordy);
            chk($sformatf("R10 vec %0d near_empty_n", i), near_empty_n, VEC[i].ae_n);
            chk($sformatf("R11 vec %0d near_full_n", i), near_full_n, VEC[i].af_n);
        end

        // Standard fill to capacity, af_ofs = 0
        af_ofs = 5'd0;
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b1, 8'h40 + 8'(i), 1'b0);
            if (i == DEPTH - 2) chk("R11 one free word", near_full_n, 1);
        end
        chk("R8 in_rdy at full", in_rdy, 0);
        chk("R11 near_full_n at full", near_full_n, 0);
        step(1'b1, 8'hEE, 1'b0);
        chk("R8 write at full dropped", in_rdy, 0);
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b0, 8'h00, 1'b1);
            chk("R12 standard order", rd_data, 8'h40 + 8'(i));
        end
        chk("R8 extra word absent", out_rdy, 0);
        step(1'b0, 8'h00, 1'b1);
        chk("R9 read when empty", rd_data, 8'h4F);

        // Fall-through mode
        do_reset(1'b0, 1'b1);
        ae_ofs = 5'd0;
        step(1'b1, 8'hB1, 1'b0);
        chk("R7 first word falls through", rd_data, 8'hB1);
        chk("R7 out_rdy raised", out_rdy, 1);
        chk("R10 level 1 above ofs 0", near_empty_n, 1);
        step(1'b1, 8'hB2, 1'b0);
        chk("R7 second word waits", rd_data, 8'hB1);
        step(1'b1, 8'hB3, 1'b0);
        step(1'b0, 8'h00, 1'b1);
        chk("R7 read advances", rd_data, 8'hB2);
        step(1'b0, 8'h00, 1'b1);
        chk("R7 read advances again", rd_data, 8'hB3);
        chk("R7 last word ready", out_rdy, 1);
        step(1'b0, 8'h00, 1'b1);
        chk("R7 out_rdy drops", out_rdy, 0);
        chk("R10 empty", near_empty_n, 0);

        for (int i = 0; i < DEPTH; i++) step(1'b1, 8'h60 + 8'(i), 1'b0);
        chk("R8 fall-through capacity", in_rdy, 0);
        chk("R11 fall-through full", near_full_n, 0);
        step(1'b1, 8'hEE, 1'b0);
        chk("R12 head word", rd_data, 8'h60);
        for (int i = 1; i < DEPTH; i++) begin
            step(1'b0, 8'h00, 1'b1);
            chk("R12 fall-through order", rd_data, 8'h60 + 8'(i));
        end
        step(1'b0, 8'h00, 1'b1);
        chk("R8 extra word absent fall-through", out_rdy, 0);

        // Asynchronous reset between edges
        step(1'b1, 8'hC1, 1'b0);
        step(1'b1, 8'hC2, 1'b0);
        #5 rst_n = 1'b0;
        #1;
        chk("R1 out_rdy cleared", out_rdy, 0);
        chk("R1 in_rdy cleared", in_rdy, 0);
        chk("R1 near_full_n set", near_full_n, 1);
        chk("R1 near_empty_n cleared", near_empty_n, 0);

        // Mode re-sampled after a new reset
        do_reset(1'b1, 1'b0);
        step(1'b1, 8'hD1, 1'b0);
        chk("R4 standard after re-reset", rd_data, 8'h00);
        chk("R4 word stored", out_rdy, 1);
        step(1'b0, 8'h00, 1'b1);
        chk("R4 explicit read", rd_data, 8'hD1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule